// File: doc/BRIEF.md
# Pairwise-Order LRU Victim Selector

This block tracks true least-recently-used order across the ways of one set. For each pair of ways it keeps a single flip-flop recording which of the two was used more recently. A hit or a fill on a way is reported through a one-cycle strobe with the way's binary index. That strobe rewrites every pair bit involving the way, so the way becomes the newest.

The victim way is decoded combinationally from the pair bits. It is the single way that is older than every other way. A cache controller reads the victim index whenever it needs a way to refill, and it reports the fill through the same strobe. Tag and data arrays live outside this block.

Top module: `lru_pairwise_victim`

## Requirements
- R1: After reset the recency order, from oldest to newest, is way 0, 1, 2, ... WAYS-1, so `victim_way` reads 0.
- R2: Once an edge has sampled `touch_valid` high with index k, `victim_way` is not k. This assumes WAYS > 1.
- R3: `victim_way` is always the least recently touched way. The reset order counts as touches of way 0 up to way WAYS-1, made before any real touch.
- R4: In a cycle with `touch_valid` low, `victim_way` keeps its value and `touch_way` has no effect.
- R5: Touching the way that is already the newest leaves `victim_way` unchanged.
- R6: Exactly one way qualifies as victim in every cycle, and `victim_way` is a binary index below WAYS.
- R7: A touch changes `victim_way` right after the clock edge that samples it, with no further cycles of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| touch_valid | input | 1 | Strobe: a way was hit or filled this cycle |
| touch_way | input | $clog2(WAYS) | Binary index of the touched way |
| victim_way | output | $clog2(WAYS) | Binary index of the least recently used way |

## Verification
The bench first touches the ways in reverse order. A pair bit written with the wrong polarity would then name the newest way, not the oldest. Idle cycles drive a changing `touch_way` while the strobe is low, which exposes a design that ignores the strobe. Repeated touches of the newest way and touches of the current victim are also driven: a decoder whose terms have swapped comparisons would jump to a wrong way or name none. A long pseudo-random stream then compares every cycle against a timestamp model, which catches any pair that is left un-updated by some index.

// File: rtl/lru_pkg.sv
package lru_pkg;
  // number of unordered way pairs
  function automatic int pair_count(input int n);
    return (n * (n - 1)) / 2;
  endfunction

  // flat slot of pair (lo,hi), lo < hi, rows laid out lo-major
  function automatic int pair_slot(input int lo, input int hi, input int n);
    return lo * n - (lo * (lo + 1)) / 2 + (hi - lo - 1);
  endfunction
endpackage

// File: rtl/lru_pair_cell.sv
// One ordering flop for ways LO < HI.
// lo_fresher = 1 : LO used more recently (HI is the older one)
// lo_fresher = 0 : HI used more recently (LO is the older one)
module lru_pair_cell #(
  parameter int IDX_W = 2,
  parameter int LO    = 0,
  parameter int HI    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_valid,
  input  logic [IDX_W-1:0] touch_way,
  output logic             lo_fresher
);
  logic hit_lo, hit_hi;
  assign hit_lo = touch_valid && (touch_way == IDX_W'(LO));
  assign hit_hi = touch_valid && (touch_way == IDX_W'(HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lo_fresher <= 1'b0;
    else if (hit_lo) lo_fresher <= 1'b1;
    else if (hit_hi) lo_fresher <= 1'b0;
  end

  // R3: the touched member of the pair becomes the fresher one
  a_r3_lo_touch_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_valid && touch_way == IDX_W'(LO)) |=> lo_fresher);
  a_r3_hi_touch_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_valid && touch_way == IDX_W'(HI)) |=> !lo_fresher);
  // R4: pair holds when neither member is touched
  a_r4_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(touch_valid && (touch_way == IDX_W'(LO) || touch_way == IDX_W'(HI)))
      |=> $stable(lo_fresher));
endmodule

// File: rtl/lru_victim_decode.sv
// Decodes pair bits into the one way older than every other way.
module lru_victim_decode #(
  parameter int WAYS  = 4,
  parameter int IDX_W = $clog2(WAYS),
  parameter int NPAIR = lru_pkg::pair_count(WAYS)
) (
  input  logic [NPAIR-1:0] order_bits,
  output logic [WAYS-1:0]  victim_hit,
  output logic [IDX_W-1:0] victim_idx
);
  import lru_pkg::*;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      victim_hit[w] = 1'b1;
      // way w as HI member: must be the older one -> lo_fresher = 1
      for (int i = 0; i < w; i++)
        victim_hit[w] &= order_bits[pair_slot(i, w, WAYS)];
      // way w as LO member: must be the older one -> lo_fresher = 0
      for (int j = w + 1; j < WAYS; j++)
        victim_hit[w] &= ~order_bits[pair_slot(w, j, WAYS)];
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int w = 0; w < WAYS; w++)
      if (victim_hit[w]) victim_idx = IDX_W'(w);
  end
endmodule

// File: rtl/lru_pairwise_victim.sv
module lru_pairwise_victim #(
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(WAYS),
  localparam int NPAIR = lru_pkg::pair_count(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_valid,
  input  logic [IDX_W-1:0] touch_way,
  output logic [IDX_W-1:0] victim_way
);
  import lru_pkg::*;

  logic [NPAIR-1:0] order_q;
  logic [WAYS-1:0]  victim_hit;

  for (genvar gi = 0; gi < WAYS; gi++) begin : g_lo
    for (genvar gj = gi + 1; gj < WAYS; gj++) begin : g_hi
      lru_pair_cell #(.IDX_W(IDX_W), .LO(gi), .HI(gj)) u_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_valid(touch_valid),
        .touch_way  (touch_way),
        .lo_fresher (order_q[pair_slot(gi, gj, WAYS)])
      );
    end
  end

  lru_victim_decode #(.WAYS(WAYS), .IDX_W(IDX_W), .NPAIR(NPAIR)) u_dec (
    .order_bits(order_q),
    .victim_hit(victim_hit),
    .victim_idx(victim_way)
  );

  // R6: pair state always encodes a total order -> one candidate
  a_r6_single_victim: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(victim_hit) == 1);
  // R2: the way just touched cannot be chosen
  a_r2_touched_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
    touch_valid |=> (victim_way != $past(touch_way)));
  // R4: no strobe, no change in the choice
  a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !touch_valid |=> $stable(victim_way));
endmodule

// File: tb/lru_pairwise_victim_test.sv
module lru_pairwise_victim_test;
  localparam int WAYS  = 4;
  localparam int IDX_W = $clog2(WAYS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             touch_valid = 1'b0;
  logic [IDX_W-1:0] touch_way = '0;
  logic [IDX_W-1:0] victim_way;

  int checks = 0;
  int fails  = 0;
  int stamp [WAYS];
  int now_t = 0;
  int exp_q [$];
  string tag_q [$];
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  lru_pairwise_victim #(.WAYS(WAYS)) uut (
    .clk(clk), .rst_n(rst_n), .touch_valid(touch_valid),
    .touch_way(touch_way), .victim_way(victim_way)
  );

  function automatic int model_victim();
    int best = 0;
    for (int w = 1; w < WAYS; w++)
      if (stamp[w] < stamp[best]) best = w;
    return best;
  endfunction

  task automatic drive(input logic v, input int k, input string tag);
    @(negedge clk);
    touch_valid = v;
    touch_way   = IDX_W'(k);
    @(posedge clk);
    if (v) begin
      stamp[k] = now_t;
      now_t++;
    end
    exp_q.push_back(model_victim());
    tag_q.push_back(tag);
  endtask

  // monitor: compares one expectation per cycle, away from the rising edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (int'(victim_way) != e) begin
        fails++;
        $display("FAIL %s: victim_way=%0d expected %0d", t, victim_way, e);
      end
      checks++;
      if (int'(victim_way) >= WAYS) begin
        fails++;
        $display("FAIL R6: victim_way=%0d expected below %0d", victim_way, WAYS);
      end
    end
  end

  task automatic run_all();
    for (int w = 0; w < WAYS; w++) stamp[w] = w - WAYS;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (victim_way != 0) begin
      fails++;
      $display("FAIL R1: victim_way=%0d expected 0 in reset", victim_way);
    end
    rst_n = 1'b1;
    drive(1'b0, 0, "R1");
    // reverse order: oldest becomes 3
    for (int k = WAYS - 1; k >= 0; k--) drive(1'b1, k, "R3");
    // R7: first sample after the edge already reflects a touch of the victim
    drive(1'b1, WAYS - 1, "R7");
    drive(1'b1, 2, "R2");
    // R5: repeated touches of the newest way
    drive(1'b1, 2, "R5");
    drive(1'b1, 2, "R5");
    // R4: strobe low with every index on touch_way
    for (int k = 0; k < WAYS; k++) drive(1'b0, k, "R4");
    // touch current victim repeatedly: rotates through the order
    for (int n = 0; n < 2 * WAYS; n++) drive(1'b1, model_victim(), "R2");
    // pseudo-random mix of touches and idles
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[7:5] != 3'd0, int'(lfsr[1:0]), lfsr[7:5] != 3'd0 ? "R3" : "R4");
    end
    @(negedge clk);
    touch_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule